// File: doc/BRIEF.md
# Transmit Packet Framer with Fill Insertion

This block sits on the transmit side of a four-lane serial link that carries fixed-length packets. Each clock it takes one word of four bytes, one byte per lane, together with one parity bit per byte and a flag that says whether the word is real data or idle. It emits one 8-bit character and one control-character indicator per lane, ready for an 8b/10b encoder on each lane.

Data packets are passed through unchanged and back to back. When the source is idle at a packet boundary, the framer builds a fill packet of the same programmed length instead. A fill packet opens with a comma character (K28.5) on all four lanes, so the receiver can find both byte and packet alignment. The remaining words of the fill packet repeat a link-control code chosen by a register input: idle, not-operational, remote-wrap or unwrap. The framer also checks the parity of every accepted data byte. If the source goes idle in the middle of a data packet, the framer reports an underrun and pads the packet to its full length.

The control state machine has four states. `ST_START` means the next word opens a packet. `ST_DATA` means a data packet is in progress. `ST_PAD` means a data packet is being padded after an underrun. `ST_FILL` means a fill packet is in progress. The transitions are:
- start-to-data: the flag is valid and the packet is longer than one word.
- start-to-fill: the flag is idle and the packet is longer than one word.
- start-to-start: the packet is one word long.
- data-to-pad: the flag drops before the last word.
- end-of-packet: any state moves back to `ST_START` on the last word of a packet.
- Otherwise each state holds.

Top module: `lane_pkt_framer`

## Requirements
- R1: While reset is low, and in the first cycle after it, all outputs are zero. The first word sampled after reset opens a new packet.
- R2: Each word of a data packet appears on the output one clock after it is sampled, unchanged. Lane i is byte bits [8i+7:8i], and the control indicator is 0 on every lane.
- R3: A data packet that ends is followed in the very next word by the next packet, with no gap cycles.
- R4: A word sampled with the flag idle at a packet boundary opens a fill packet. The fill packet lasts exactly the programmed number of words.
- R5: The first word of every fill packet is 0xBC on all four lanes with the control indicator set on all four lanes. No other word sets the control indicator.
- R6: Every later word of a fill packet carries the code on all lanes with the control indicator clear. The codes are 0x00 idle, 0x01 not-operational, 0x02 remote-wrap and 0x03 unwrap. The code is captured from the code input when the fill packet opens, so later changes to that input have no effect until the next fill packet.
- R7: The packet length, in words, is captured only when a packet opens, so a change mid-packet does not alter the current packet. A programmed value of 0 acts as 1, and a value above 64 acts as 64.
- R8: If the flag is idle on a word after the first word of a data packet, underrun pulses for that one word. That word and every remaining word of the packet are output as zero bytes with the control indicator clear, even if the flag returns.
- R9: Parity is even: a byte is correct when its parity bit equals the XOR of its eight bits. A mismatch on an accepted data byte raises that lane's parity-error bit in the same cycle the byte is output, and the byte still passes through unchanged. Bytes that are not accepted as data raise no parity error.
- R10: A valid flag during a fill packet is ignored. The fill packet runs to its full length, and the data offered in those cycles is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | 1 = data word, 0 = idle |
| in_data | input | 32 | Four input bytes, lane i at bits [8i+7:8i] |
| in_par | input | 4 | Even parity bit per lane |
| cfg_len | input | 7 | Packet length in words, captured at packet start |
| cfg_code | input | 2 | Fill code select, captured at fill start |
| out_char | output | 32 | Output character per lane |
| out_k | output | 4 | Control-character indicator per lane |
| par_err | output | 4 | Per-lane parity error pulse |
| underrun | output | 1 | Data packet underrun pulse |

## Verification
All results — character, indicator, parity error and underrun — are registered, so each is due exactly one clock after the word that caused it is sampled. The bench drives each word just after a falling edge and advances a behavioural model of the packet sequencing with that same word. It then compares every output at the next falling edge, half a period after the rising edge that loads the result. Length and code changes, mid-packet flag changes and parity faults are therefore judged against the packet that was open when they arrived.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_DATA  = 2'd1,
        ST_PAD   = 2'd2,
        ST_FILL  = 2'd3
    } lpf_state_e;

    typedef enum logic [1:0] {
        WK_DATA  = 2'd0,
        WK_ZERO  = 2'd1,
        WK_COMMA = 2'd2,
        WK_CODE  = 2'd3
    } lpf_word_e;

    localparam int        CODE_W     = 2;
    localparam logic [7:0] COMMA_CHAR = 8'hBC;
endpackage

// File: rtl/lpf_len_ctr.sv
module lpf_len_ctr #(
    parameter int MAX_WORDS = 64,
    parameter int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_step,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             last_word
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] MAX = LEN_W'(MAX_WORDS);

    logic [LEN_W-1:0] len_now;
    logic [LEN_W-1:0] rem_q;

    always_comb begin
        if (cfg_len == '0)      len_now = ONE;
        else if (cfg_len > MAX) len_now = MAX;
        else                    len_now = cfg_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rem_q <= '0;
        else if (pkt_start) rem_q <= len_now - ONE;
        else if (pkt_step)  rem_q <= rem_q - ONE;
    end

    assign last_word = pkt_start ? (len_now == ONE) : (rem_q == ONE);

    p_rem_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_step |-> rem_q != '0);
    p_rem_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q < MAX);
endmodule

// File: rtl/lpf_par_chk.sv
module lpf_par_chk #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] data,
    input  logic [LANES-1:0]   par,
    input  logic               en,
    output logic [LANES-1:0]   err
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign err[i] = en & (par[i] ^ (^data[8*i +: 8]));
    end
endmodule

// File: rtl/lpf_lane_mux.sv
module lpf_lane_mux
    import lpf_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lpf_word_e          kind,
    input  logic [8*LANES-1:0] data,
    input  logic [CODE_W-1:0]  code,
    output logic [8*LANES-1:0] chr,
    output logic [LANES-1:0]   k
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (kind)
                WK_DATA:  begin chr[8*i +: 8] = data[8*i +: 8];            k[i] = 1'b0; end
                WK_ZERO:  begin chr[8*i +: 8] = 8'h00;                     k[i] = 1'b0; end
                WK_COMMA: begin chr[8*i +: 8] = COMMA_CHAR;                k[i] = 1'b1; end
                WK_CODE:  begin chr[8*i +: 8] = {{(8-CODE_W){1'b0}}, code}; k[i] = 1'b0; end
                default:  begin chr[8*i +: 8] = 8'h00;                     k[i] = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/lane_pkt_framer.sv
module lane_pkt_framer
    import lpf_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int MAX_WORDS = 64,
    parameter int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [8*LANES-1:0] in_data,
    input  logic [LANES-1:0]   in_par,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [CODE_W-1:0]  cfg_code,
    output logic [8*LANES-1:0] out_char,
    output logic [LANES-1:0]   out_k,
    output logic [LANES-1:0]   par_err,
    output logic               underrun
);
    localparam int WORD_W = 8 * LANES;

    lpf_state_e          state_q, state_d;
    lpf_word_e           kind;
    logic                pkt_start, pkt_step, last_word, und_d;
    logic [CODE_W-1:0]   code_q;
    logic [WORD_W-1:0]   chr_d;
    logic [LANES-1:0]    k_d, perr_d;

    lpf_len_ctr #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) i_len_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .pkt_step  (pkt_step),
        .cfg_len   (cfg_len),
        .last_word (last_word)
    );

    lpf_par_chk #(.LANES(LANES)) i_par_chk (
        .data (in_data),
        .par  (in_par),
        .en   (kind == WK_DATA),
        .err  (perr_d)
    );

    lpf_lane_mux #(.LANES(LANES)) i_lane_mux (
        .kind (kind),
        .data (in_data),
        .code (code_q),
        .chr  (chr_d),
        .k    (k_d)
    );

    assign pkt_start = (state_q == ST_START);
    assign pkt_step  = !pkt_start;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        kind    = WK_ZERO;
        und_d   = 1'b0;
        unique case (state_q)
            ST_START: begin
                kind    = in_vld ? WK_DATA : WK_COMMA;
                state_d = last_word ? ST_START : (in_vld ? ST_DATA : ST_FILL);
            end
            ST_DATA: begin
                kind    = in_vld ? WK_DATA : WK_ZERO;
                und_d   = !in_vld;
                state_d = last_word ? ST_START : (in_vld ? ST_DATA : ST_PAD);
            end
            ST_PAD: begin
                kind    = WK_ZERO;
                state_d = last_word ? ST_START : ST_PAD;
            end
            ST_FILL: begin
                kind    = WK_CODE;
                state_d = last_word ? ST_START : ST_FILL;
            end
            default: begin
                kind    = WK_ZERO;
                state_d = ST_START;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    code_q <= '0;
        else if (pkt_start && !in_vld) code_q <= cfg_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_char <= '0;
            out_k    <= '0;
            par_err  <= '0;
            underrun <= 1'b0;
        end else begin
            out_char <= chr_d;
            out_k    <= k_d;
            par_err  <= perr_d;
            underrun <= und_d;
        end
    end

    p_k_all_or_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_k == '0) || (out_k == {LANES{1'b1}}));
    p_comma_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_k != '0) |-> $past(state_q) == ST_START);
    p_fill_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> ($past(state_q) == ST_START || $past(state_q) == ST_FILL));
    p_pad_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD) |-> ($past(state_q) == ST_DATA || $past(state_q) == ST_PAD));
    p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (out_char == '0 && out_k == '0));
    p_perr_data_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err != '0) |-> (out_k == '0 && !underrun));
endmodule

// File: tb/test_lane_pkt_framer.sv
module test_lane_pkt_framer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_par = '0;
    logic [6:0]  cfg_len = 7'd4;
    logic [1:0]  cfg_code = '0;
    logic [31:0] out_char;
    logic [3:0]  out_k, par_err;
    logic        underrun;

    int checks = 0;
    int failures = 0;

    // behavioural reference: 0 start, 1 data, 2 pad, 3 fill
    int          m_state = 0;
    int          m_rem = 0;
    logic [1:0]  m_code = '0;
    logic [31:0] e_char = '0;
    logic [3:0]  e_k = '0, e_perr = '0;
    logic        e_und = 1'b0;
    string       e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_pkt_framer i_lane_pkt_framer (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .in_par(in_par), .cfg_len(cfg_len), .cfg_code(cfg_code),
        .out_char(out_char), .out_k(out_k), .par_err(par_err), .underrun(underrun)
    );

    function automatic logic [3:0] even_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    function automatic int clamp_len(input int l);
        if (l == 0) return 1;
        if (l > 64) return 64;
        return l;
    endfunction

    task automatic model_step(input logic v, input logic [31:0] d, input logic [3:0] p,
                              input int len, input logic [1:0] c);
        int L; bit last; bit take;
        take = 0; e_und = 0; e_k = '0; e_char = '0;
        if (m_state == 0) begin
            L = clamp_len(len);
            last = (L == 1);
            m_rem = L - 1;
            if (v) begin take = 1; e_tag = "R2/R3"; m_state = last ? 0 : 1; end
            else begin
                e_char = {4{8'hBC}}; e_k = 4'hF; e_tag = "R4/R5";
                m_code = c; m_state = last ? 0 : 3;
            end
        end else begin
            last = (m_rem == 1);
            m_rem = m_rem - 1;
            if (m_state == 1 && v) begin take = 1; e_tag = "R2"; end
            else if (m_state == 1) begin e_und = 1; e_tag = "R8"; m_state = 2; end
            else if (m_state == 2) e_tag = "R8";
            else begin e_char = {4{6'b0, m_code}}; e_tag = "R6/R10"; end
            if (last) m_state = 0;
        end
        if (take) e_char = d;
        e_perr = take ? (p ^ even_par(d)) : 4'h0;
    endtask

    task automatic compare(input string ph);
        checks++;
        if (out_char !== e_char || out_k !== e_k || underrun !== e_und) begin
            failures++;
            $display("FAIL %s %s: char=%h k=%h und=%b expected char=%h k=%h und=%b",
                     e_tag, ph, out_char, out_k, underrun, e_char, e_k, e_und);
        end
        checks++;
        if (par_err !== e_perr) begin
            failures++;
            $display("FAIL R9 %s: par_err=%h expected %h", ph, par_err, e_perr);
        end
    endtask

    task automatic cyc(input logic v, input logic [31:0] d, input logic [3:0] pflip,
                       input int len, input logic [1:0] c, input string ph);
        in_vld = v; in_data = d; in_par = even_par(d) ^ pflip;
        cfg_len = 7'(len); cfg_code = c;
        model_step(v, d, in_par, len, c);
        @(posedge clk);
        @(negedge clk);
        compare(ph);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        in_vld = 1'b1; in_data = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset
        e_char = '0; e_k = '0; e_perr = '0; e_und = 0; e_tag = "R1";
        compare("reset");
        rst_n = 1'b1;
        m_state = 0;
        // R2/R3: three back-to-back data packets of length 4
        for (int i = 0; i < 12; i++) cyc(1, 32'h01020304 * (i + 1), 4'h0, 4, 0, "b2b R3");
        // R4/R5/R6: fill packet, code change mid-fill ignored
        cyc(0, 0, 4'h0, 5, 2, "fill R4");
        for (int i = 0; i < 4; i++) cyc(0, 0, 4'h0, 5, 1, "code hold R6");
        cyc(0, 0, 4'h0, 5, 3, "fill unwrap R5");
        // R10: valid flag mid-fill ignored
        for (int i = 0; i < 4; i++) cyc(1, 32'hA5A5A5A5 + i, 4'h0, 5, 0, "fill ignores data R10");
        // R8: underrun mid-packet, flag returns
        cyc(1, 32'h11223344, 4'h0, 6, 0, "underrun start R8");
        cyc(1, 32'h55667788, 4'h0, 6, 0, "underrun R8");
        cyc(0, 32'h99AABBCC, 4'h0, 6, 0, "underrun drop R8");
        for (int i = 0; i < 3; i++) cyc(1, 32'hCAFEF00D, 4'h0, 6, 0, "pad hold R8");
        // R9: parity errors on data words only
        cyc(1, 32'h0F0F0F0F, 4'h5, 3, 0, "parity R9");
        cyc(1, 32'h80402010, 4'hA, 3, 0, "parity R9");
        cyc(1, 32'h7E7E7E7E, 4'h0, 3, 0, "parity clean R9");
        cyc(0, 32'h12345678, 4'hF, 3, 0, "no parity in fill R9");
        cyc(1, 32'h12345678, 4'hF, 3, 0, "no parity in fill R9");
        cyc(1, 32'h12345678, 4'hF, 3, 0, "no parity in fill R9");
        // R7: length changes mid-packet, clamps
        cyc(1, 32'h1, 4'h0, 3, 0, "len hold R7");
        cyc(1, 32'h2, 4'h0, 1, 0, "len hold R7");
        cyc(1, 32'h3, 4'h0, 9, 0, "len hold R7");
        for (int i = 0; i < 3; i++) cyc(0, 0, 4'h0, 0, 1, "len zero R7");
        for (int i = 0; i < 3; i++) cyc(1, 32'h100 + i, 4'h0, 1, 0, "len one R7");
        for (int i = 0; i < 130; i++) cyc(i == 0 || i > 70, 32'h200 + i, 4'h0, 100, 2, "len clamp R7");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic v; logic [3:0] pf;
            v  = ($urandom_range(0, 9) < 7);
            pf = ($urandom_range(0, 19) == 0) ? 4'($urandom) : 4'h0;
            cyc(v, $urandom, pf, $urandom_range(0, 70) / ((i % 50 == 0) ? 1 : 8),
                2'($urandom), "random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule